// File: doc/BRIEF.md
# In-System Programming Stage Sequencer

This controller takes a programmable logic device through its in-system programming procedure. A single start pulse launches a run, and a mode input chooses either a full program run or a verify-only run. The controller moves through a fixed order of stages. It holds the entry, exit and erase stages for fixed times, counted in clock cycles. In the program and verify stages it visits every memory address in ascending order.

The controller does not shift bits itself. For each serial transaction it raises a request to an external shift engine, giving an operation code, an address and a data word. The engine answers with a one-cycle acknowledge and a returned word. Programming pulses, read pulses and the erase pulse appear on one pulse output. Expected pattern words come from a synchronous memory port with one cycle of read latency.

At the end of a run the controller gives a one-cycle done strobe, together with either pass or fail. The error code and the failing address stay valid until the next run starts. The current stage is shown at all times as a 3-bit code.

Top module: `isp_sequencer`

## Requirements
- R1: The `stage` output uses these codes: 0 idle, 1 entry, 2 identifier check, 3 erase, 4 program, 5 verify, 6 exit, 7 finish. After reset it is 0. A full run (`verify_only`=0 when `start` is taken) shows stages 1, 2, 3, 4, 5, 6, 7 in that order and then returns to 0.
- R2: A verify-only run (`verify_only`=1 when `start` is taken) shows stages 1, 2, 5, 6, 7, then 0. It never issues an erase or load operation.
- R3: The entry stage lasts exactly ENTER_MS*CYC_PER_MS cycles. The exit stage lasts exactly EXIT_MS*CYC_PER_MS cycles.
- R4: The erase stage issues exactly one erase operation (op code 1). After that operation it holds `pulse` high for exactly ERASE_MS*CYC_PER_MS cycles.
- R5: The program stage visits addresses 0 up to the last address in order. For each address it issues one load operation (op code 2) carrying the address and the memory word at that address. It then holds `pulse` for PROG_PULSE cycles.
- R6: The verify stage visits addresses in ascending order. For each address it issues a read-address operation (op code 3), holds `pulse` for READ_PULSE cycles, and then issues an unload operation (op code 4). The word returned by the unload is compared with the memory word. A run with no mismatch ends in pass.
- R7: The first operation of every run is an identifier read (op code 0). If the returned word differs from ID_VALUE, the run goes straight to exit and ends in fail with `err_code`=1. No erase, load, read-address or unload operation is issued.
- R8: On the first verify mismatch, `fail_addr` captures that address and `err_code` becomes 2. The run goes straight to exit and ends in fail, and no further address is read.
- R9: `done` is high for exactly one cycle per run. In that cycle exactly one of `pass` and `fail` is high. Outside that cycle both are low.
- R10: A `start` pulse that arrives while a run is in progress has no effect on the stage order, the operations issued or the number of done strobes.
- R11: A request stays high, with its op code, address and data unchanged, until `sh_ack` is seen. In idle there is no request and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run launch pulse, taken only in idle |
| verify_only | input | 1 | Mode sampled with start: 1 = verify-only run |
| sh_req | output | 1 | Shift transaction request |
| sh_op | output | 3 | Operation code (0 id read, 1 erase, 2 load, 3 read address, 4 unload) |
| sh_addr | output | ADDR_W | Address for load and read-address operations |
| sh_wdata | output | DATA_W | Data word for load operations |
| sh_ack | input | 1 | One-cycle completion of the current request |
| sh_rdata | input | DATA_W | Word shifted back, valid with sh_ack |
| pulse | output | 1 | Erase, program or read pulse to the device |
| mem_rd_en | output | 1 | Expected-pattern memory read enable |
| mem_addr | output | ADDR_W | Expected-pattern memory address |
| mem_rdata | input | DATA_W | Memory word, valid the cycle after mem_rd_en |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run succeeded, valid with done |
| fail | output | 1 | Run failed, valid with done |
| fail_addr | output | ADDR_W | Address of the first verify mismatch |
| err_code | output | 2 | 0 none, 1 identifier mismatch, 2 verify mismatch |
| stage | output | 3 | Current stage code |

## Verification
Two events can land in the same cycle.

The first pair is a new `start` and a busy run. The bench raises `start` with the opposite mode while a run is in its program stage. It then checks that the recorded stage trace, the operation counts and the single done strobe match an undisturbed full run.

The second pair is a verify mismatch and the end of the address walk. The bench corrupts the word read back at the last address, so the mismatch exit and the normal last-address exit compete in the same cycle. It then checks for `fail_addr` equal to the last address, error code 2, and one unload for each address.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

    typedef enum logic [2:0] {
        STG_IDLE   = 3'd0,
        STG_ENTER  = 3'd1,
        STG_CHKID  = 3'd2,
        STG_ERASE  = 3'd3,
        STG_PROG   = 3'd4,
        STG_VERIFY = 3'd5,
        STG_EXIT   = 3'd6,
        STG_FINISH = 3'd7
    } stage_e;

    typedef enum logic [2:0] {
        OP_IDREAD = 3'd0,
        OP_ERASE  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_RADDR  = 3'd3,
        OP_UNLOAD = 3'd4
    } shop_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_ID     = 2'd1,
        ERR_VERIFY = 2'd2
    } err_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_ENTER, SQ_ID_SHIFT, SQ_ER_SHIFT, SQ_ER_PULSE,
        SQ_PG_FETCH, SQ_PG_LATCH, SQ_PG_SHIFT, SQ_PG_PULSE,
        SQ_VF_FETCH, SQ_VF_LATCH, SQ_VF_ADDR, SQ_VF_PULSE, SQ_VF_SHIFT,
        SQ_EXIT, SQ_FINISH
    } seq_state_e;

    // Per-state decode of the control outputs
    typedef struct packed {
        logic  req;
        shop_e op;
        logic  pulse;
        logic  mem_rd;
    } drive_t;

    function automatic stage_e stage_of(seq_state_e s);
        case (s)
            SQ_IDLE:                                   return STG_IDLE;
            SQ_ENTER:                                  return STG_ENTER;
            SQ_ID_SHIFT:                               return STG_CHKID;
            SQ_ER_SHIFT, SQ_ER_PULSE:                  return STG_ERASE;
            SQ_PG_FETCH, SQ_PG_LATCH, SQ_PG_SHIFT,
            SQ_PG_PULSE:                               return STG_PROG;
            SQ_VF_FETCH, SQ_VF_LATCH, SQ_VF_ADDR,
            SQ_VF_PULSE, SQ_VF_SHIFT:                  return STG_VERIFY;
            SQ_EXIT:                                   return STG_EXIT;
            default:                                   return STG_FINISH;
        endcase
    endfunction

    function automatic drive_t drive_of(seq_state_e s);
        drive_t d;
        d = '{req: 1'b0, op: OP_IDREAD, pulse: 1'b0, mem_rd: 1'b0};
        case (s)
            SQ_ID_SHIFT: begin d.req = 1'b1; d.op = OP_IDREAD; end
            SQ_ER_SHIFT: begin d.req = 1'b1; d.op = OP_ERASE;  end
            SQ_PG_SHIFT: begin d.req = 1'b1; d.op = OP_LOAD;   end
            SQ_VF_ADDR:  begin d.req = 1'b1; d.op = OP_RADDR;  end
            SQ_VF_SHIFT: begin d.req = 1'b1; d.op = OP_UNLOAD; end
            SQ_ER_PULSE, SQ_PG_PULSE, SQ_VF_PULSE: d.pulse = 1'b1;
            SQ_PG_FETCH, SQ_VF_FETCH:              d.mem_rd = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

    // Stage steps allowed between consecutive cycles
    function automatic logic legal_step(stage_e a, stage_e b);
        case (a)
            STG_IDLE:   return b == STG_ENTER;
            STG_ENTER:  return b == STG_CHKID;
            STG_CHKID:  return (b == STG_ERASE) || (b == STG_VERIFY) || (b == STG_EXIT);
            STG_ERASE:  return b == STG_PROG;
            STG_PROG:   return b == STG_VERIFY;
            STG_VERIFY: return b == STG_EXIT;
            STG_EXIT:   return b == STG_FINISH;
            default:    return b == STG_IDLE;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/isp_dwell_timer.sv
module isp_dwell_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // A load of N makes expired rise in the N-th cycle after the load edge
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - TW'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/isp_addr_walker.sv
module isp_addr_walker #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            addr_q <= '0;
        else if (step)
            addr_q <= addr_q + ADDR_W'(1);
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == LAST);
endmodule

// File: rtl/isp_fault_latch.sv
module isp_fault_latch
    import isp_seq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              id_bad,
    input  logic              vf_bad,
    input  logic [ADDR_W-1:0] addr_in,
    output err_e              err,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              failed
);
    err_e              err_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_q  <= ERR_NONE;
            addr_q <= '0;
        end else if (id_bad) begin
            err_q  <= ERR_ID;
        end else if (vf_bad) begin
            err_q  <= ERR_VERIFY;
            addr_q <= addr_in;
        end
    end

    assign err       = err_q;
    assign fail_addr = addr_q;
    assign failed    = (err_q != ERR_NONE);
endmodule

// File: rtl/isp_sequencer.sv
module isp_sequencer
    import isp_seq_pkg::*;
#(
    parameter int              CYC_PER_MS = 200000,
    parameter int              ENTER_MS   = 1,
    parameter int              EXIT_MS    = 1,
    parameter int              ERASE_MS   = 100,
    parameter int              PROG_PULSE = 8,
    parameter int              READ_PULSE = 4,
    parameter int              ADDR_W     = 4,
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              verify_only,
    output logic              sh_req,
    output logic [2:0]        sh_op,
    output logic [ADDR_W-1:0] sh_addr,
    output logic [DATA_W-1:0] sh_wdata,
    input  logic              sh_ack,
    input  logic [DATA_W-1:0] sh_rdata,
    output logic              pulse,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [1:0]        err_code,
    output logic [2:0]        stage
);
    localparam int ENTER_CYC = ENTER_MS * CYC_PER_MS;
    localparam int EXIT_CYC  = EXIT_MS * CYC_PER_MS;
    localparam int ERASE_CYC = ERASE_MS * CYC_PER_MS;
    localparam int MAX_CYC   = max3(max3(ENTER_CYC, EXIT_CYC, ERASE_CYC),
                                    PROG_PULSE, READ_PULSE);
    localparam int TW        = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] ENTER_V = TW'(ENTER_CYC);
    localparam logic [TW-1:0] EXIT_V  = TW'(EXIT_CYC);
    localparam logic [TW-1:0] ERASE_V = TW'(ERASE_CYC);
    localparam logic [TW-1:0] PROG_V  = TW'(PROG_PULSE);
    localparam logic [TW-1:0] READ_V  = TW'(READ_PULSE);

    seq_state_e        state_q, state_d;
    logic              vo_q;
    logic [DATA_W-1:0] exp_q;
    drive_t            drv;

    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              walk_clr, walk_step, at_last;
    logic [ADDR_W-1:0] addr;
    logic              run_clr, id_bad, vf_bad, failed;
    err_e              err;

    isp_dwell_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    isp_addr_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk     (clk),
        .rst     (rst),
        .clr     (walk_clr),
        .step    (walk_step),
        .addr    (addr),
        .at_last (at_last)
    );

    isp_fault_latch #(.ADDR_W(ADDR_W)) u_fault (
        .clk       (clk),
        .rst       (rst),
        .clr       (run_clr),
        .id_bad    (id_bad),
        .vf_bad    (vf_bad),
        .addr_in   (addr),
        .err       (err),
        .fail_addr (fail_addr),
        .failed    (failed)
    );

    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        walk_clr  = 1'b0;
        walk_step = 1'b0;
        run_clr   = 1'b0;
        id_bad    = 1'b0;
        vf_bad    = 1'b0;
        unique case (state_q)
            SQ_IDLE: if (start) begin
                state_d  = SQ_ENTER;
                tmr_load = 1'b1;
                tmr_val  = ENTER_V;
                walk_clr = 1'b1;
                run_clr  = 1'b1;
            end
            SQ_ENTER: if (tmr_exp) state_d = SQ_ID_SHIFT;
            SQ_ID_SHIFT: if (sh_ack) begin
                if (sh_rdata != ID_VALUE) begin
                    id_bad   = 1'b1;
                    state_d  = SQ_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = EXIT_V;
                end else if (vo_q) begin
                    state_d = SQ_VF_FETCH;
                end else begin
                    state_d = SQ_ER_SHIFT;
                end
            end
            SQ_ER_SHIFT: if (sh_ack) begin
                state_d  = SQ_ER_PULSE;
                tmr_load = 1'b1;
                tmr_val  = ERASE_V;
            end
            SQ_ER_PULSE: if (tmr_exp) state_d = SQ_PG_FETCH;
            SQ_PG_FETCH: state_d = SQ_PG_LATCH;
            SQ_PG_LATCH: state_d = SQ_PG_SHIFT;
            SQ_PG_SHIFT: if (sh_ack) begin
                state_d  = SQ_PG_PULSE;
                tmr_load = 1'b1;
                tmr_val  = PROG_V;
            end
            SQ_PG_PULSE: if (tmr_exp) begin
                if (at_last) begin
                    walk_clr = 1'b1;
                    state_d  = SQ_VF_FETCH;
                end else begin
                    walk_step = 1'b1;
                    state_d   = SQ_PG_FETCH;
                end
            end
            SQ_VF_FETCH: state_d = SQ_VF_LATCH;
            SQ_VF_LATCH: state_d = SQ_VF_ADDR;
            SQ_VF_ADDR: if (sh_ack) begin
                state_d  = SQ_VF_PULSE;
                tmr_load = 1'b1;
                tmr_val  = READ_V;
            end
            SQ_VF_PULSE: if (tmr_exp) state_d = SQ_VF_SHIFT;
            SQ_VF_SHIFT: if (sh_ack) begin
                if (sh_rdata != exp_q) begin
                    vf_bad   = 1'b1;
                    state_d  = SQ_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = EXIT_V;
                end else if (at_last) begin
                    state_d  = SQ_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = EXIT_V;
                end else begin
                    walk_step = 1'b1;
                    state_d   = SQ_VF_FETCH;
                end
            end
            SQ_EXIT:   if (tmr_exp) state_d = SQ_FINISH;
            SQ_FINISH: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            vo_q    <= 1'b0;
            exp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && start)
                vo_q <= verify_only;
            if (state_q == SQ_PG_LATCH || state_q == SQ_VF_LATCH)
                exp_q <= mem_rdata;
        end
    end

    assign drv       = drive_of(state_q);
    assign sh_req    = drv.req;
    assign sh_op     = drv.op;
    assign sh_addr   = addr;
    assign sh_wdata  = exp_q;
    assign pulse     = drv.pulse;
    assign mem_rd_en = drv.mem_rd;
    assign mem_addr  = addr;
    assign done      = (state_q == SQ_FINISH);
    assign pass      = done && !failed;
    assign fail      = done && failed;
    assign err_code  = err;
    assign stage     = stage_of(state_q);
endmodule

// File: rtl/isp_sequencer_chk.sv
module isp_sequencer_chk
    import isp_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              sh_req,
    input logic              sh_ack,
    input logic [2:0]        sh_op,
    input logic [ADDR_W-1:0] sh_addr,
    input logic [DATA_W-1:0] sh_wdata,
    input logic              pulse,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [2:0]        stage,
    input logic              mode_vo
);
    AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (stage != $past(stage)) |-> legal_step(stage_e'($past(stage)), stage_e'(stage))); // R1

    AST_VO_SKIPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        mode_vo |-> (stage != 3'd3 && stage != 3'd4)); // R2

    AST_PULSE_NOT_SHIFT: assert property (@(posedge clk) disable iff (rst)
        pulse |-> !sh_req); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({pass, fail})); // R9

    AST_VERDICT_GATED: assert property (@(posedge clk) disable iff (rst)
        (pass || fail) |-> done); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && stage != 3'd0) |=> (stage != 3'd1 || $past(stage) == 3'd1)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sh_req && !sh_ack) |=> (sh_req && $stable(sh_op) && $stable(sh_addr) && $stable(sh_wdata))); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (stage == 3'd0) |-> (!sh_req && !pulse)); // R11
endmodule

bind isp_sequencer isp_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sh_req   (sh_req),
    .sh_ack   (sh_ack),
    .sh_op    (sh_op),
    .sh_addr  (sh_addr),
    .sh_wdata (sh_wdata),
    .pulse    (pulse),
    .done     (done),
    .pass     (pass),
    .fail     (fail),
    .stage    (stage),
    .mode_vo  (vo_q)
);

// File: tb/isp_sequencer_test.sv
`timescale 1ns/1ps
module isp_sequencer_test;
    localparam int CPM   = 10;
    localparam int ER_MS = 100;
    localparam int PP    = 3;
    localparam int RP    = 2;
    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int NADDR = 1 << AW;
    localparam logic [DW-1:0] IDV = 8'h5C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          verify_only = 1'b0;
    logic          sh_req;
    logic [2:0]    sh_op;
    logic [AW-1:0] sh_addr;
    logic [DW-1:0] sh_wdata;
    logic          sh_ack = 1'b0;
    logic [DW-1:0] sh_rdata = '0;
    logic          pulse, mem_rd_en, done, pass, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic [1:0]    err_code;
    logic [2:0]    stage;

    isp_sequencer #(
        .CYC_PER_MS(CPM), .ENTER_MS(1), .EXIT_MS(1), .ERASE_MS(ER_MS),
        .PROG_PULSE(PP), .READ_PULSE(RP), .ADDR_W(AW), .DATA_W(DW), .ID_VALUE(IDV)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .verify_only(verify_only),
        .sh_req(sh_req), .sh_op(sh_op), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
        .sh_ack(sh_ack), .sh_rdata(sh_rdata), .pulse(pulse),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
        .err_code(err_code), .stage(stage)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    bit timed_out = 1'b0;

    // device and run records
    logic [DW-1:0] image [NADDR];
    logic [DW-1:0] dev_id = IDV;
    bit            corrupt_on = 1'b0;
    int            corrupt_addr = 0;
    int            last_raddr = 0;
    int            lat = 0;
    logic [2:0]    h_op;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] h_wdata;
    bit            hold_bad;
    logic [31:0]   seq;
    logic [2:0]    prev_stage = 3'd0;
    int stg_cyc [8];
    int pulse_cyc [8];
    int op_cnt [5];
    int first_op, done_cyc, load_next, vf_next;
    bit load_bad, vf_order_bad;
    logic last_pass, last_fail;
    logic [AW-1:0] last_faddr;
    logic [1:0]    last_err;

    function automatic logic [DW-1:0] exp_word(input int a);
        return DW'((a * 37 + 5) & 255);
    endfunction

    task automatic clear_stats();
        seq = '0; hold_bad = 0; first_op = -1; done_cyc = 0;
        load_next = 0; vf_next = 0; load_bad = 0; vf_order_bad = 0;
        last_pass = 0; last_fail = 0; last_faddr = '0; last_err = '0;
        for (int i = 0; i < 8; i++) begin stg_cyc[i] = 0; pulse_cyc[i] = 0; end
        for (int i = 0; i < 5; i++) op_cnt[i] = 0;
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor, memory model and shift-engine model, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000 && !timed_out) begin
                timed_out = 1'b1;
                failures++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
            if (!rst) begin
                if (stage != prev_stage) begin
                    seq = (seq << 4) | 32'(stage);
                    prev_stage = stage;
                end
                stg_cyc[stage]++;
                if (pulse) pulse_cyc[stage]++;
                if (done) begin
                    done_cyc++;
                    last_pass = pass; last_fail = fail;
                    last_faddr = fail_addr; last_err = err_code;
                end
                if (mem_rd_en) mem_rdata = exp_word(int'(mem_addr));
                if (sh_ack) begin
                    sh_ack = 1'b0;
                end else if (sh_req) begin
                    lat++;
                    if (lat == 1) begin h_op = sh_op; h_addr = sh_addr; h_wdata = sh_wdata; end
                    if (lat == 2) begin
                        lat = 0;
                        if (h_op != sh_op || h_addr != sh_addr || h_wdata != sh_wdata) hold_bad = 1;
                        if (first_op < 0) first_op = int'(sh_op);
                        if (sh_op <= 3'd4) op_cnt[sh_op]++;
                        sh_rdata = '0;
                        case (sh_op)
                            3'd0: sh_rdata = dev_id;
                            3'd1: for (int i = 0; i < NADDR; i++) image[i] = '1;
                            3'd2: begin
                                image[sh_addr] = sh_wdata;
                                if (int'(sh_addr) != load_next || sh_wdata != exp_word(int'(sh_addr)))
                                    load_bad = 1;
                                load_next++;
                            end
                            3'd3: begin
                                last_raddr = int'(sh_addr);
                                if (int'(sh_addr) != vf_next) vf_order_bad = 1;
                                vf_next++;
                            end
                            default: sh_rdata = image[last_raddr] ^
                                ((corrupt_on && last_raddr == corrupt_addr) ? 8'h10 : 8'h00);
                        endcase
                        sh_ack = 1'b1;
                    end
                end
            end
        end
    end

    task automatic run_seq(input bit vo, input bit inject);
        bit injected = 0;
        @(negedge clk); #1;
        clear_stats();
        start = 1'b1; verify_only = vo;
        @(negedge clk); #1;
        start = 1'b0;
        while (done_cyc == 0 && !timed_out) begin
            @(negedge clk); #1;
            if (inject && !injected && stage == 3'd4) begin
                start = 1'b1; verify_only = ~vo; injected = 1;
                @(negedge clk); #1;
                start = 1'b0; verify_only = vo;
            end
        end
        repeat (3) @(negedge clk);
        #1;
        verify_only = 1'b0;
    endtask

    task automatic preset_image();
        for (int i = 0; i < NADDR; i++) image[i] = exp_word(i);
    endtask

    task automatic test_reset();
        chk("R1 reset stage", int'(stage), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset pass/fail", int'({pass, fail}), 0);
        chk("R11 reset quiet", int'({sh_req, pulse, mem_rd_en}), 0);
    endtask

    task automatic test_full();
        for (int i = 0; i < NADDR; i++) image[i] = 8'h00;
        dev_id = IDV; corrupt_on = 0;
        run_seq(1'b0, 1'b0);
        chk("R1 full stage trace", int'(seq), 32'h12345670);
        chk("R3 entry dwell", stg_cyc[1], CPM);
        chk("R3 exit dwell", stg_cyc[6], CPM);
        chk("R4 erase op count", op_cnt[1], 1);
        chk("R4 erase pulse", pulse_cyc[3], ER_MS * CPM);
        chk("R5 load count", op_cnt[2], NADDR);
        chk("R5 load order/data", int'(load_bad), 0);
        chk("R5 program pulses", pulse_cyc[4], NADDR * PP);
        for (int i = 0; i < NADDR; i++)
            chk("R5 image word", int'(image[i]), int'(exp_word(i)));
        chk("R6 unload count", op_cnt[4], NADDR);
        chk("R6 read order", int'(vf_order_bad), 0);
        chk("R6 read pulses", pulse_cyc[5], NADDR * RP);
        chk("R6 pass", int'({last_pass, last_fail}), 2);
        chk("R7 first op id read", first_op, 0);
        chk("R9 done cycles", done_cyc, 1);
        chk("R9 err none", int'(last_err), 0);
        chk("R11 request hold", int'(hold_bad), 0);
    endtask

    task automatic test_verify_only();
        preset_image(); dev_id = IDV; corrupt_on = 0;
        run_seq(1'b1, 1'b0);
        chk("R2 trace", int'(seq), 32'h125670);
        chk("R2 no erase/load", op_cnt[1] + op_cnt[2], 0);
        chk("R2 unload count", op_cnt[4], NADDR);
        chk("R2 pass", int'({last_pass, last_fail}), 2);
        chk("R3 exit dwell vo", stg_cyc[6], CPM);
    endtask

    task automatic test_id_mismatch();
        preset_image(); dev_id = IDV ^ 8'h01; corrupt_on = 0;
        run_seq(1'b0, 1'b0);
        chk("R7 trace", int'(seq), 32'h12670);
        chk("R7 fail", int'({last_pass, last_fail}), 1);
        chk("R7 err code", int'(last_err), 1);
        chk("R7 no later ops", op_cnt[1] + op_cnt[2] + op_cnt[3] + op_cnt[4], 0);
        chk("R7 only id read", op_cnt[0], 1);
        dev_id = IDV;
    endtask

    task automatic test_verify_mismatch(input int at, input bit vo);
        if (vo) preset_image();
        dev_id = IDV; corrupt_on = 1; corrupt_addr = at;
        run_seq(vo, 1'b0);
        chk("R8 trace", int'(seq), vo ? 32'h125670 : 32'h12345670);
        chk("R8 fail", int'({last_pass, last_fail}), 1);
        chk("R8 fail addr", int'(last_faddr), at);
        chk("R8 err code", int'(last_err), 2);
        chk("R8 unloads stop", op_cnt[4], at + 1);
        chk("R9 done cycles on fail", done_cyc, 1);
        corrupt_on = 0;
    endtask

    task automatic test_busy_start();
        dev_id = IDV; corrupt_on = 0;
        run_seq(1'b0, 1'b1);
        chk("R10 trace unchanged", int'(seq), 32'h12345670);
        chk("R10 single done", done_cyc, 1);
        chk("R10 load count", op_cnt[2], NADDR);
        chk("R10 entry once", stg_cyc[1], CPM);
        chk("R10 pass, err cleared", int'({last_pass, last_fail, last_err}), 8);
    endtask

    initial begin
        clear_stats();
        repeat (5) @(negedge clk);
        #1;
        test_reset();
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 idle after reset", int'(stage), 0);
        test_full();
        test_verify_only();
        test_id_mismatch();
        test_verify_mismatch(5, 1'b1);
        test_verify_mismatch(NADDR - 1, 1'b0);
        test_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule